// File: doc/BRIEF.md
# First-Fault Vector Load Unit

This block performs a contiguous vector load of 64-bit elements in which only the first active element may raise a real fault. A fault on any later element is absorbed. The block records it by clearing bits of a first-fault register (FFR), and no further memory accesses are made. The FFR holds one bit per byte lane of the longest vector. Software starts a load sequence with a set command. It then issues loads and reads the FFR back as a predicate, ANDed with a governing predicate, to find out which elements hold valid data.

Commands arrive on one command port and take one of three forms: set, load, or read. A load carries a base address, a starting element index and a governing predicate. The block then walks the elements in ascending order, one per cycle, through a memory port. That port answers in the same cycle with data and a fault flag. The vector length is 128, 256 or 512 bits, selected by a mode input.

Top module: `ffld_unit`

## Requirements
- R1: After reset, `busy`, `trap`, `ld_done`, `rd_valid` and `mem_req` are 0, and `ffr_out` and `ld_data` are all zero.
- R2: A set command (`cmd_op`=1) makes `ffr_out` equal, one cycle later, to ones in byte lanes 0 up to VL/8-1 and zeros above.
- R3: A load command (`cmd_op`=2) reads active element e at address base + (index + e)*8, in ascending e, one element per cycle. With no fault, `ld_done` pulses for one cycle N cycles after the command edge, where N is the number of elements.
- R4: Inactive elements cause no memory access and read as zero in `ld_data`. A load with no active element completes with an all-zero result.
- R5: If the lowest-numbered active element faults, `trap` pulses for one cycle one cycle after that access. `ld_done` stays low, `ld_data` keeps its previous value, and `ffr_out` is unchanged.
- R6: If a later active element e faults, no trap is raised. `ld_done` pulses, FFR lanes 8e and up are cleared, elements below e keep their loaded data, and elements e and up read as zero.
- R7: After a non-first element faults, no access is made to any higher element of that load.
- R8: A read command (`cmd_op`=3) pulses `rd_valid` one cycle later, with `rd_pred` = FFR AND `cmd_pred` AND the byte-lane mask of the current vector length.
- R9: `vl_mode` 0, 1 and 2 select 128, 256 and 512 bits (2, 4 and 8 elements). Mode 3 acts as 512. The mode is sampled when a command is accepted.
- R10: Commands presented while `busy` is high are ignored.
- R11: The predicate bit of element e is `cmd_pred` bit 8e, and element e occupies `ld_data` bits 64e+63 down to 64e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_mode | input | 2 | Vector length select |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 set FFR, 2 load, 3 read FFR |
| cmd_base | input | ADDR_W | Load base address |
| cmd_index | input | ADDR_W | Starting element index |
| cmd_pred | input | MAX_VL_BITS/8 | Governing predicate, one bit per byte lane |
| busy | output | 1 | Load in progress |
| mem_req | output | 1 | Element access strobe |
| mem_addr | output | ADDR_W | Element address |
| mem_rdata | input | ELEM_W | Element data, same cycle |
| mem_fault | input | 1 | Access fault, same cycle |
| ld_done | output | 1 | Load finished pulse |
| ld_data | output | MAX_VL_BITS | Loaded vector |
| trap | output | 1 | First-element fault pulse |
| ffr_out | output | MAX_VL_BITS/8 | Current FFR |
| rd_valid | output | 1 | Read result strobe |
| rd_pred | output | MAX_VL_BITS/8 | FFR AND predicate AND lane mask |

## Verification
Some rules are checked on every cycle by the assertions. These are: a trap never coincides with completion; a trap leaves the FFR and the result vector untouched; addresses step by eight between back-to-back active elements; no access follows an absorbed fault; an absorbed fault leaves the FFR clear from the faulting lane upward; and a read result never exceeds the FFR. Other behaviour can only be shown by the bench's scenarios. This covers the exact data placement and zero-filling, the completion latency in each length mode, the choice of which element counts as first under a sparse predicate, access counts, and commands being ignored while a load runs.

// File: rtl/ffld_pkg.sv
package ffld_pkg;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_SETFFR = 2'd1,
    OP_LOAD   = 2'd2,
    OP_RDFFR  = 2'd3
  } ffld_op_e;

  localparam int unsigned ELEM_BYTES = 8;

  // Number of 64-bit elements for a length mode, capped at the maximum.
  function automatic int unsigned mode_elems(input logic [1:0] mode,
                                             input int unsigned max_e);
    int unsigned n;
    n = 32'd2 << mode;
    return (n > max_e) ? max_e : n;
  endfunction

  // Byte address of element e of a load.
  function automatic logic [63:0] elem_addr(input logic [63:0] base,
                                            input logic [63:0] index,
                                            input logic [63:0] e);
    return base + ((index + e) * 64'(ELEM_BYTES));
  endfunction

endpackage

// File: rtl/ffld_walker.sv
module ffld_walker #(
  parameter int ELEMS  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int CNT_W = $clog2(ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ELEMS-1:0]  elem_pred,
  input  logic [CNT_W-1:0]  nelem,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_fault,
  output logic              busy,
  output logic              ev_ok,
  output logic              ev_soft,
  output logic              ev_hard,
  output logic              ev_finish,
  output logic [IDX_W-1:0]  ev_elem
);

  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [CNT_W-1:0]  nelem_q;
  logic [CNT_W-1:0]  first_q;
  logic [ELEMS-1:0]  pred_q;
  logic [ADDR_W-1:0] base_q, index_q;
  logic [ELEMS-1:0]  pred_in;
  logic [CNT_W-1:0]  first_in;
  logic              is_first, is_last, cur_act;

  // Clip the incoming predicate to the selected length.
  for (genvar e = 0; e < ELEMS; e++) begin : g_clip
    assign pred_in[e] = elem_pred[e] && (CNT_W'(e) < nelem);
  end

  always_comb begin
    first_in = CNT_W'(ELEMS);
    for (int e = ELEMS - 1; e >= 0; e--) begin
      if (pred_in[e]) first_in = CNT_W'(e);
    end
  end

  assign cur_act   = pred_q[cur_q];
  assign is_first  = (CNT_W'(cur_q) == first_q);
  assign is_last   = (CNT_W'(cur_q) + CNT_W'(1) == nelem_q);
  assign mem_req   = busy_q && cur_act;
  assign mem_addr  = ADDR_W'(ffld_pkg::elem_addr(64'(base_q), 64'(index_q), 64'(cur_q)));
  assign ev_ok     = mem_req && !mem_fault;
  assign ev_hard   = mem_req && mem_fault && is_first;
  assign ev_soft   = mem_req && mem_fault && !is_first;
  assign ev_finish = busy_q && !ev_hard && (ev_soft || is_last);
  assign ev_elem   = cur_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      nelem_q <= '0;
      first_q <= '0;
      pred_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
    end else if (busy_q) begin
      if (ev_hard || ev_finish) busy_q <= 1'b0;
      else                      cur_q  <= cur_q + IDX_W'(1);
    end else if (start) begin
      busy_q  <= 1'b1;
      cur_q   <= '0;
      nelem_q <= nelem;
      first_q <= first_in;
      pred_q  <= pred_in;
      base_q  <= base;
      index_q <= index;
    end
  end

  // R7: an absorbed fault ends all accesses of the load
  p_silent_after_soft_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft |=> !mem_req);

  // R3: back-to-back active elements of one load are 8 bytes apart
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && $past(busy_q) && !$past(ev_finish))
      |-> (mem_addr - $past(mem_addr)) == ADDR_W'(8));

  // R10: a start while a load runs does not restart the walk
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ev_finish && !ev_hard) |=> (busy_q && cur_q == $past(cur_q) + IDX_W'(1)));

endmodule

// File: rtl/ffld_collect.sv
module ffld_collect #(
  parameter int ELEMS  = 8,
  parameter int ELEM_W = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int VEC_W = ELEMS * ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ev_ok,
  input  logic              ev_hard,
  input  logic              ev_finish,
  input  logic [IDX_W-1:0]  ev_elem,
  input  logic [ELEM_W-1:0] rdata,
  output logic [VEC_W-1:0]  ld_data,
  output logic              ld_done,
  output logic              trap
);

  logic [ELEMS-1:0][ELEM_W-1:0] acc_q, acc_nx, out_q;
  logic done_q, trap_q;

  // Unwritten elements stay zero because the accumulator clears at start.
  for (genvar e = 0; e < ELEMS; e++) begin : g_lane
    assign acc_nx[e] = (ev_ok && ev_elem == IDX_W'(e)) ? rdata : acc_q[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      out_q  <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      done_q <= ev_finish;
      trap_q <= ev_hard;
      if (start)          acc_q <= '0;
      else                acc_q <= acc_nx;
      if (ev_finish)      out_q <= acc_nx;
    end
  end

  assign ld_data = out_q;
  assign ld_done = done_q;
  assign trap    = trap_q;

  // R5: trap and completion are exclusive
  p_trap_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_q && done_q));

  // R5: a first-element fault leaves the result vector untouched
  p_trap_keeps_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hard |=> (trap_q && $stable(out_q)));

endmodule

// File: rtl/ffld_ffr.sv
module ffld_ffr #(
  parameter int ELEMS  = 8,
  parameter int LPE    = 8,
  localparam int LANES = ELEMS * LPE,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int CNT_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_set,
  input  logic             do_rd,
  input  logic [CNT_W-1:0] nelem,
  input  logic             ev_soft,
  input  logic             ev_hard,
  input  logic [IDX_W-1:0] ev_elem,
  input  logic [LANES-1:0] rd_mask,
  output logic [LANES-1:0] ffr_out,
  output logic             rd_valid,
  output logic [LANES-1:0] rd_pred
);

  logic [LANES-1:0] ffr_q, vl_lanes, cut_lanes, rd_q;
  logic             rdv_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign vl_lanes[i]  = (CNT_W'(i / LPE) < nelem);
    assign cut_lanes[i] = ev_soft && (IDX_W'(i / LPE) >= ev_elem);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ffr_q <= '0;
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= do_rd;
      if (do_rd)        rd_q  <= ffr_q & rd_mask & vl_lanes;
      if (do_set)       ffr_q <= vl_lanes;
      else if (ev_soft) ffr_q <= ffr_q & ~cut_lanes;
    end
  end

  assign ffr_out  = ffr_q;
  assign rd_valid = rdv_q;
  assign rd_pred  = rd_q;

  // R6: after an absorbed fault nothing at or above its lane survives
  p_soft_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft |=> ((ffr_q >> (32'($past(ev_elem)) * LPE)) == '0));

  // R5: a first-element fault does not touch the FFR
  p_hard_keeps_ffr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hard |=> $stable(ffr_q));

  // R8: a read never reports a lane the FFR does not hold
  p_rd_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> ((rd_q & ~ffr_q) == '0));

endmodule

// File: rtl/ffld_unit.sv
module ffld_unit #(
  parameter int MAX_VL_BITS = 512,
  parameter int ADDR_W      = 32,
  parameter int ELEM_W      = 64,
  localparam int ELEMS = MAX_VL_BITS / ELEM_W,
  localparam int LPE   = ELEM_W / 8,
  localparam int LANES = MAX_VL_BITS / 8,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int CNT_W = $clog2(ELEMS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             vl_mode,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic [ADDR_W-1:0]      cmd_index,
  input  logic [LANES-1:0]       cmd_pred,
  output logic                   busy,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [ELEM_W-1:0]      mem_rdata,
  input  logic                   mem_fault,
  output logic                   ld_done,
  output logic [MAX_VL_BITS-1:0] ld_data,
  output logic                   trap,
  output logic [LANES-1:0]       ffr_out,
  output logic                   rd_valid,
  output logic [LANES-1:0]       rd_pred
);
  import ffld_pkg::*;

  logic             accept, do_set, do_load, do_rd;
  logic [ELEMS-1:0] elem_pred;
  logic [CNT_W-1:0] cur_elems;
  logic             ev_ok, ev_soft, ev_hard, ev_finish;
  logic [IDX_W-1:0] ev_elem;
  logic             busy_w;

  assign accept    = cmd_valid && !busy_w;
  assign do_set    = accept && (ffld_op_e'(cmd_op) == OP_SETFFR);
  assign do_load   = accept && (ffld_op_e'(cmd_op) == OP_LOAD);
  assign do_rd     = accept && (ffld_op_e'(cmd_op) == OP_RDFFR);
  assign cur_elems = CNT_W'(mode_elems(vl_mode, ELEMS));
  assign busy      = busy_w;

  for (genvar e = 0; e < ELEMS; e++) begin : g_pred
    assign elem_pred[e] = cmd_pred[e * LPE];
  end

  ffld_walker #(.ELEMS(ELEMS), .ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(do_load), .elem_pred(elem_pred),
    .nelem(cur_elems), .base(cmd_base), .index(cmd_index),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_fault(mem_fault),
    .busy(busy_w), .ev_ok(ev_ok), .ev_soft(ev_soft), .ev_hard(ev_hard),
    .ev_finish(ev_finish), .ev_elem(ev_elem)
  );

  ffld_collect #(.ELEMS(ELEMS), .ELEM_W(ELEM_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .start(do_load), .ev_ok(ev_ok),
    .ev_hard(ev_hard), .ev_finish(ev_finish), .ev_elem(ev_elem),
    .rdata(mem_rdata), .ld_data(ld_data), .ld_done(ld_done), .trap(trap)
  );

  ffld_ffr #(.ELEMS(ELEMS), .LPE(LPE)) u_ffr (
    .clk(clk), .rst_n(rst_n), .do_set(do_set), .do_rd(do_rd),
    .nelem(cur_elems), .ev_soft(ev_soft), .ev_hard(ev_hard),
    .ev_elem(ev_elem), .rd_mask(cmd_pred), .ffr_out(ffr_out),
    .rd_valid(rd_valid), .rd_pred(rd_pred)
  );

  // R10: commands are not accepted during a load
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !(do_set || do_load || do_rd));

endmodule

// File: tb/ffld_unit_bench.sv
module ffld_unit_bench;
  localparam int VLB = 512;
  localparam int AW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     vl_mode = 2'd2;
  logic           cmd_valid = 1'b0;
  logic [1:0]     cmd_op = 2'd0;
  logic [AW-1:0]  cmd_base = '0, cmd_index = '0;
  logic [63:0]    cmd_pred = '0;
  logic           busy, mem_req, mem_fault, ld_done, trap, rd_valid;
  logic [AW-1:0]  mem_addr;
  logic [63:0]    mem_rdata, ffr_out, rd_pred;
  logic [VLB-1:0] ld_data;

  logic          fault_en = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  int            acc_cnt = 0, beyond = 0;
  int            checks = 0, fails = 0;
  bit            finished = 0;

  always #10 clk = ~clk;

  assign mem_fault = mem_req && fault_en && (mem_addr == fault_addr);
  assign mem_rdata = {~mem_addr, mem_addr};

  always @(posedge clk) if (mem_req) begin
    acc_cnt++;
    if (fault_en && mem_addr > fault_addr) beyond++;
  end

  ffld_unit u_ffld_unit (
    .clk(clk), .rst_n(rst_n), .vl_mode(vl_mode), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_base(cmd_base), .cmd_index(cmd_index),
    .cmd_pred(cmd_pred), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_fault(mem_fault), .ld_done(ld_done),
    .ld_data(ld_data), .trap(trap), .ffr_out(ffr_out), .rd_valid(rd_valid),
    .rd_pred(rd_pred)
  );

  task automatic chk(input bit ok, input string tag, input logic [VLB-1:0] act,
                     input logic [VLB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VLB-1:0] exp_vec(input logic [AW-1:0] base,
      input logic [AW-1:0] idx, input logic [7:0] got);
    logic [VLB-1:0] v = '0;
    for (int e = 0; e < 8; e++) begin
      logic [AW-1:0] a = base + (idx + AW'(e)) * 8;
      if (got[e]) v[e*64 +: 64] = {~a, a};
    end
    return v;
  endfunction

  function automatic logic [63:0] lanes(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] mode,
      input logic [AW-1:0] base, input logic [AW-1:0] idx, input logic [63:0] pred);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; vl_mode = mode;
    cmd_base = base; cmd_index = idx; cmd_pred = pred;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end(output int k);
    k = 0;
    while (!ld_done && !trap && k < 40) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    chk(!busy && !trap && !ld_done && !rd_valid && !mem_req, "R1 ctrl low",
        {busy, trap, ld_done, rd_valid, mem_req}, 0);
    chk(ffr_out == 0 && ld_data == 0, "R1 state zero", ffr_out, 0);
  endtask

  task automatic t_set_modes;
    send(2'd1, 2'd0, 0, 0, 0);
    chk(ffr_out == lanes(16), "R2 R9 set mode0", ffr_out, lanes(16));
    send(2'd1, 2'd1, 0, 0, 0);
    chk(ffr_out == lanes(32), "R2 R9 set mode1", ffr_out, lanes(32));
    send(2'd1, 2'd3, 0, 0, 0);
    chk(ffr_out == lanes(64), "R2 R9 set mode3", ffr_out, lanes(64));
  endtask

  task automatic t_clean(input logic [1:0] mode, input int n);
    int k;
    fault_en = 1'b0; acc_cnt = 0;
    send(2'd2, mode, 32'h1000, 32'd3, '1);
    wait_end(k);
    chk(ld_done && k == n, "R3 R9 latency", k, n);
    chk(ld_data == exp_vec(32'h1000, 3, 8'((1 << n) - 1)), "R3 R11 data",
        ld_data, exp_vec(32'h1000, 3, 8'((1 << n) - 1)));
    chk(acc_cnt == n, "R3 access count", acc_cnt, n);
    @(negedge clk);
    chk(!ld_done, "R3 done one cycle", ld_done, 0);
  endtask

  task automatic t_sparse;
    int k;
    fault_en = 1'b0; acc_cnt = 0;
    send(2'd2, 2'd2, 32'h2000, 0, 64'h0100_0001_0000_0100); // elems 1,4,7
    wait_end(k);
    chk(ld_data == exp_vec(32'h2000, 0, 8'b1001_0010), "R4 R11 inactive zero",
        ld_data, exp_vec(32'h2000, 0, 8'b1001_0010));
    chk(acc_cnt == 3, "R4 no inactive access", acc_cnt, 3);
    acc_cnt = 0;
    send(2'd2, 2'd2, 32'h2000, 0, 64'hFEFE_FEFE_FEFE_FEFE); // no bit 8e set
    wait_end(k);
    chk(ld_done && ld_data == 0 && acc_cnt == 0, "R4 empty predicate", ld_data, 0);
  endtask

  task automatic t_hard;
    int k;
    logic [VLB-1:0] prev;
    logic [63:0] fprev;
    send(2'd1, 2'd2, 0, 0, 0);
    prev = ld_data; fprev = ffr_out;
    fault_en = 1'b1; fault_addr = 32'h3000 + 2 * 8; acc_cnt = 0;
    send(2'd2, 2'd2, 32'h3000, 0, 64'h0000_0000_0101_0000); // elems 2,3
    wait_end(k);
    chk(trap && !ld_done && k == 3, "R5 trap timing", k, 3);
    chk(ld_data == prev, "R5 data kept", ld_data, prev);
    chk(ffr_out == fprev, "R5 ffr kept", ffr_out, fprev);
    chk(acc_cnt == 1, "R5 single access", acc_cnt, 1);
    @(negedge clk);
    chk(!trap && !ld_done, "R5 trap one cycle", trap, 0);
  endtask

  task automatic t_soft;
    int k;
    send(2'd1, 2'd2, 0, 0, 0);
    fault_en = 1'b1; fault_addr = 32'h4000 + 5 * 8; acc_cnt = 0; beyond = 0;
    send(2'd2, 2'd2, 32'h4000, 0, '1);
    wait_end(k);
    chk(ld_done && !trap && k == 6, "R6 completes", k, 6);
    chk(ffr_out == lanes(40), "R6 ffr cleared", ffr_out, lanes(40));
    chk(ld_data == exp_vec(32'h4000, 0, 8'h1F), "R6 data zero upward",
        ld_data, exp_vec(32'h4000, 0, 8'h1F));
    chk(acc_cnt == 6 && beyond == 0, "R7 no later access", acc_cnt, 6);
    fault_en = 1'b0;
  endtask

  task automatic t_read;
    send(2'd3, 2'd2, 0, 0, '1);
    chk(rd_valid && rd_pred == lanes(40), "R8 read full", rd_pred, lanes(40));
    send(2'd3, 2'd1, 0, 0, 64'hF0F0_F0F0_0F0F_0F0F);
    chk(rd_valid && rd_pred == 64'h0000_0000_0F0F_0F0F, "R8 R9 read masked",
        rd_pred, 64'h0F0F_0F0F);
    @(negedge clk);
    chk(!rd_valid, "R8 valid one cycle", rd_valid, 0);
  endtask

  task automatic t_busy;
    int k;
    acc_cnt = 0;
    send(2'd2, 2'd2, 32'h5000, 0, '1);
    send(2'd1, 2'd2, 0, 0, 0);
    chk(busy && !rd_valid, "R10 busy seen", busy, 1);
    send(2'd3, 2'd2, 0, 0, '1);
    chk(!rd_valid, "R10 read ignored", rd_valid, 0);
    send(2'd2, 2'd2, 32'h9000, 0, '1);
    wait_end(k);
    chk(ld_done && acc_cnt == 8, "R10 load ignored", acc_cnt, 8);
    chk(ffr_out == lanes(40), "R10 set ignored", ffr_out, lanes(40));
    chk(ld_data == exp_vec(32'h5000, 0, 8'hFF), "R10 first load intact",
        ld_data, exp_vec(32'h5000, 0, 8'hFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_modes();
    t_clean(2'd2, 8);
    t_clean(2'd0, 2);
    t_clean(2'd1, 4);
    t_sparse();
    t_hard();
    t_soft();
    t_read();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule